// File: doc/BRIEF.md
# Flash Write Status Read Generator

This block sits on the read path of a NOR-style flash device and chooses the word that a host read returns. When no internal program or erase is running, the word comes straight from the array. While an internal program or erase runs, a set of status bits replaces the array word. The host polls these bits to learn when the write has finished. A polling bit reports completion, and a toggle bit changes on every read while the device is busy. A region bit lets the host find the region that is being erased or that has an erase on hold.

The command decoder supplies busy, erase and suspend flags, the target address of the operation, and a region mask that marks the address bits lying inside the erased region. The mask covers a sector, a block or the whole chip. After an erase is put on hold, the block keeps reporting erase status for a programmable settling delay. After that delay, reads outside the held region return array data. Reads inside the held region keep returning a suspend signature. The read result is registered on the read strobe and holds until the next strobe.

Top module: `flash_status_rdgen`

## Requirements
- R1: After reset `rd_q` is 0. With `op_busy` low, a read strobe loads `rd_q` with `arr_data` at the next clock edge. Without a strobe, `rd_q` keeps its value.
- R2: While a program runs (`op_busy`=1, `op_erase`=0), bit 7 of the read word is the complement of `prog_poll_bit`.
- R3: While an erase runs and is not held, bit 7 of the read word is 0.
- R4: During a program, or during an erase that is not held, bit 6 of the read word takes opposite values on successive reads. The first such read after reset returns 0.
- R5: During an erase that is not held, bit 2 is 0 for a read outside the region. Inside the region, bit 2 takes opposite values on successive in-region reads, and reads outside the region do not disturb this sequence. An address is inside the region when it equals `op_addr` on every bit where `region_mask` is 0.
- R6: During any status read, every bit other than 7, 6 and 2 reads 0, and bit 2 reads 0 during a program.
- R7: When `op_susp` rises during an erase, reads keep returning erase status, with bit 6 still alternating, for `SUSP_CYC` clock edges after the edge that first samples `op_susp` high.
- R8: Once the settling delay has passed with `op_susp` still high, reads outside the region return `arr_data`.
- R9: Once held, reads inside the region return bit 6 = 1, bit 7 = 0, and bit 2 continuing its alternation. These reads do not advance the bit 6 sequence.
- R10: When `op_busy` falls, reads return `arr_data`. The bit 6 sequence stays frozen across idle reads, so the next busy read returns the opposite of the last busy value.
- R11: When `op_susp` falls, reads return erase status again at once, and bits 6 and 2 continue their sequences.
- R12: A `region_mask` of all ones places every address inside the region, which gives a chip-wide erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_addr | input | AW | Read address |
| arr_data | input | DW | Array word at `rd_addr` |
| op_busy | input | 1 | Internal program or erase in progress |
| op_erase | input | 1 | 1: the running operation is an erase, 0: a program |
| op_susp | input | 1 | Erase put on hold by the decoder |
| op_addr | input | AW | Target address of the running operation |
| region_mask | input | AW | 1 marks an address bit that varies within the erased region |
| prog_poll_bit | input | 1 | Bit 7 of the word being programmed |
| rd_q | output | DW | Read word |

## Verification
The bench tracks its own toggle sequences and interleaves in-region and out-of-region reads. A design that advanced the region bit on every read, or that stopped the status toggle while idle, would break the expected alternation. It reads during the suspend settling window: a design that switched early would return array data where erase status belongs. After the hold, it checks that the signature does not advance bit 6. It also restarts an operation after idle reads and after a resume, which exposes toggle state that is reset or lost when the mode changes.

// File: rtl/fsrg_pkg.sv
package fsrg_pkg;

  typedef enum logic [1:0] {
    VIEW_ARRAY = 2'd0,
    VIEW_PROG  = 2'd1,
    VIEW_ERASE = 2'd2,
    VIEW_HELD  = 2'd3
  } view_t;

  typedef enum logic [1:0] {
    SP_RUN  = 2'd0,
    SP_WAIT = 2'd1,
    SP_HELD = 2'd2
  } susp_st_t;

  localparam int BIT_POLL   = 7;
  localparam int BIT_TGL    = 6;
  localparam int BIT_REGION = 2;

endpackage

// File: rtl/fsrg_susp_timer.sv
module fsrg_susp_timer #(
  parameter int SUSP_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic op_busy,
  input  logic op_erase,
  input  logic op_susp,
  output logic held
);
  import fsrg_pkg::*;

  localparam int CW = $clog2(SUSP_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SUSP_CYC - 1);

  susp_st_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic hold_req;

  assign hold_req = op_busy & op_erase & op_susp;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!hold_req) begin
      st_d  = SP_RUN;
      cnt_d = '0;
    end else begin
      case (st_q)
        SP_RUN: begin
          st_d  = SP_WAIT;
          cnt_d = '0;
        end
        SP_WAIT: begin
          if (cnt_q == LAST) st_d = SP_HELD;
          else               cnt_d = cnt_q + 1'b1;
        end
        default: st_d = SP_HELD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SP_RUN;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign held = hold_req & (st_q == SP_HELD);

endmodule

// File: rtl/fsrg_region.sv
module fsrg_region #(
  parameter int AW = 20
) (
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] op_addr,
  input  logic [AW-1:0] region_mask,
  output logic          in_region
);
  logic [AW-1:0] diff;

  assign diff      = (rd_addr ^ op_addr) & ~region_mask;
  assign in_region = (diff == '0);

endmodule

// File: rtl/fsrg_toggle.sv
module fsrg_toggle (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_stb,
  input  fsrg_pkg::view_t view,
  input  logic            in_region,
  output logic            t6,
  output logic            t2
);
  import fsrg_pkg::*;

  logic t6_en, t2_en;

  assign t6_en = rd_stb & ((view == VIEW_PROG) | (view == VIEW_ERASE));
  assign t2_en = rd_stb & in_region & ((view == VIEW_ERASE) | (view == VIEW_HELD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t6 <= 1'b0;
      t2 <= 1'b0;
    end else begin
      if (t6_en) t6 <= ~t6;
      if (t2_en) t2 <= ~t2;
    end
  end

endmodule

// File: rtl/fsrg_word_mux.sv
module fsrg_word_mux #(
  parameter int DW = 16
) (
  input  fsrg_pkg::view_t view,
  input  logic            in_region,
  input  logic [DW-1:0]   arr_data,
  input  logic            prog_poll_bit,
  input  logic            t6,
  input  logic            t2,
  output logic [DW-1:0]   word
);
  import fsrg_pkg::*;

  always_comb begin
    word = '0;
    case (view)
      VIEW_PROG: begin
        word[BIT_POLL] = ~prog_poll_bit;
        word[BIT_TGL]  = t6;
      end
      VIEW_ERASE: begin
        word[BIT_TGL]    = t6;
        word[BIT_REGION] = in_region & t2;
      end
      VIEW_HELD: begin
        if (in_region) begin
          word[BIT_TGL]    = 1'b1;
          word[BIT_REGION] = t2;
        end else begin
          word = arr_data;
        end
      end
      default: word = arr_data;
    endcase
  end

endmodule

// File: rtl/flash_status_rdgen.sv
module flash_status_rdgen #(
  parameter int DW       = 16,
  parameter int AW       = 20,
  parameter int SUSP_CYC = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] arr_data,
  input  logic          op_busy,
  input  logic          op_erase,
  input  logic          op_susp,
  input  logic [AW-1:0] op_addr,
  input  logic [AW-1:0] region_mask,
  input  logic          prog_poll_bit,
  output logic [DW-1:0] rd_q
);
  import fsrg_pkg::*;

  logic          held;
  logic          in_region;
  logic          t6, t2;
  view_t         view;
  logic [DW-1:0] word;
  logic [DW-1:0] rd_d;

  fsrg_susp_timer #(.SUSP_CYC(SUSP_CYC)) i_susp (
    .clk(clk), .rst_n(rst_n), .op_busy(op_busy), .op_erase(op_erase),
    .op_susp(op_susp), .held(held)
  );

  fsrg_region #(.AW(AW)) i_region (
    .rd_addr(rd_addr), .op_addr(op_addr), .region_mask(region_mask),
    .in_region(in_region)
  );

  always_comb begin
    if (!op_busy)      view = VIEW_ARRAY;
    else if (held)     view = VIEW_HELD;
    else if (op_erase) view = VIEW_ERASE;
    else               view = VIEW_PROG;
  end

  fsrg_toggle i_tgl (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .view(view),
    .in_region(in_region), .t6(t6), .t2(t2)
  );

  fsrg_word_mux #(.DW(DW)) i_mux (
    .view(view), .in_region(in_region), .arr_data(arr_data),
    .prog_poll_bit(prog_poll_bit), .t6(t6), .t2(t2), .word(word)
  );

  always_comb begin
    rd_d = rd_q;
    if (rd_stb) rd_d = word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

endmodule

// File: rtl/fsrg_checker.sv
module fsrg_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_stb,
  input logic [DW-1:0] arr_data,
  input logic          op_busy,
  input logic          op_erase,
  input logic          op_susp,
  input logic          prog_poll_bit,
  input logic [DW-1:0] rd_q
);
  localparam logic [DW-1:0] STAT_MASK = DW'(8'hC4);

  logic live;
  assign live = op_busy & ~op_susp;

  a_r1_idle_array: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !op_busy) |=> (rd_q == $past(arr_data)));

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_q));

  a_r2_poll_prog: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && op_busy && !op_erase) |=> (rd_q[7] == !$past(prog_poll_bit)));

  a_r3_poll_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && live && op_erase) |=> !rd_q[7]);

  a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && live && $past(rd_stb && live)) |=> (rd_q[6] != $past(rd_q[6])));

  a_r6_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && live) |=> ((rd_q & ~STAT_MASK) == '0));

endmodule

bind flash_status_rdgen fsrg_checker #(.DW(DW)) i_fsrg_checker (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .arr_data(arr_data),
  .op_busy(op_busy), .op_erase(op_erase), .op_susp(op_susp),
  .prog_poll_bit(prog_poll_bit), .rd_q(rd_q)
);

// File: tb/test_flash_status_rdgen.sv
module test_flash_status_rdgen;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 20;
  localparam int SUSP_CYC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_stb = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] arr_data = '0;
  logic op_busy = 1'b0, op_erase = 1'b0, op_susp = 1'b0, prog_poll_bit = 1'b0;
  logic [AW-1:0] op_addr = '0, region_mask = '0;
  logic [DW-1:0] rd_q;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit m6 = 0, m2 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_rdgen #(.DW(DW), .AW(AW), .SUSP_CYC(SUSP_CYC)) i_flash_status_rdgen (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .arr_data(arr_data), .op_busy(op_busy), .op_erase(op_erase),
    .op_susp(op_susp), .op_addr(op_addr), .region_mask(region_mask),
    .prog_poll_bit(prog_poll_bit), .rd_q(rd_q)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] arr, output logic [DW-1:0] q);
    @(negedge clk);
    rd_addr = a; arr_data = arr; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    q = rd_q;
  endtask

  function automatic logic [DW-1:0] stat(bit b7, bit b6, bit b2);
    return DW'({b7, b6, 3'b000, b2, 2'b00});
  endfunction

  task automatic t_reset();
    chk("R1 reset", rd_q, '0);
  endtask

  task automatic t_idle();
    logic [DW-1:0] q;
    rd(20'h00010, 16'h1234, q); chk("R1 idle read", q, 16'h1234);
    rd(20'h00020, 16'hA5C3, q); chk("R1 idle read", q, 16'hA5C3);
    @(negedge clk); arr_data = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R1 hold without strobe", rd_q, 16'hA5C3);
  endtask

  task automatic t_program();
    logic [DW-1:0] q;
    @(negedge clk); op_busy = 1; op_erase = 0; prog_poll_bit = 1;
    for (int i = 0; i < 3; i++) begin
      rd(20'h00100, 16'hFFFF, q);
      chk("R2 R4 R6 program status", q, stat(0, m6, 0)); m6 = ~m6;
    end
    @(negedge clk); prog_poll_bit = 0;
    rd(20'h00100, 16'h0000, q);
    chk("R2 polling complement", q, stat(1, m6, 0)); m6 = ~m6;
  endtask

  task automatic t_complete();
    logic [DW-1:0] q;
    @(negedge clk); op_busy = 0;
    rd(20'h00100, 16'h0F0F, q); chk("R10 completion data", q, 16'h0F0F);
    rd(20'h00200, 16'h7E7E, q); chk("R10 idle data", q, 16'h7E7E);
    @(negedge clk); op_busy = 1; prog_poll_bit = 0;
    rd(20'h00300, 16'h0000, q);
    chk("R10 toggle frozen while idle", q, stat(1, m6, 0)); m6 = ~m6;
    @(negedge clk); op_busy = 0;
  endtask

  task automatic t_erase();
    logic [DW-1:0] q;
    @(negedge clk);
    op_busy = 1; op_erase = 1; op_addr = 20'h12800; region_mask = 20'h007FF;
    rd(20'h12ABC, 16'hFFFF, q); chk("R3 R5 erase in region", q, stat(0, m6, m2)); m6 = ~m6; m2 = ~m2;
    rd(20'h12801, 16'hFFFF, q); chk("R5 erase in region", q, stat(0, m6, m2)); m6 = ~m6; m2 = ~m2;
    rd(20'h13000, 16'hFFFF, q); chk("R5 R6 erase out of region", q, stat(0, m6, 0)); m6 = ~m6;
    rd(20'h12FFF, 16'hFFFF, q); chk("R5 sequence kept", q, stat(0, m6, m2)); m6 = ~m6; m2 = ~m2;
  endtask

  task automatic t_suspend();
    logic [DW-1:0] q;
    @(negedge clk); op_susp = 1;
    rd(20'h13000, 16'h5A5A, q); chk("R7 settling status", q, stat(0, m6, 0)); m6 = ~m6;
    rd(20'h12800, 16'h5A5A, q); chk("R7 settling in region", q, stat(0, m6, m2)); m6 = ~m6; m2 = ~m2;
    repeat (SUSP_CYC + 2) @(negedge clk);
    rd(20'h13000, 16'h5A5A, q); chk("R8 held outside", q, 16'h5A5A);
    rd(20'h00000, 16'hC0DE, q); chk("R8 held outside", q, 16'hC0DE);
    rd(20'h12900, 16'h5A5A, q); chk("R9 held signature", q, stat(0, 1, m2)); m2 = ~m2;
    rd(20'h12900, 16'h5A5A, q); chk("R9 held signature", q, stat(0, 1, m2)); m2 = ~m2;
  endtask

  task automatic t_resume();
    logic [DW-1:0] q;
    @(negedge clk); op_susp = 0;
    rd(20'h12A00, 16'h5A5A, q); chk("R11 R9 resume continues", q, stat(0, m6, m2)); m6 = ~m6; m2 = ~m2;
    rd(20'h13000, 16'h5A5A, q); chk("R11 resume outside", q, stat(0, m6, 0)); m6 = ~m6;
  endtask

  task automatic t_chip();
    logic [DW-1:0] q;
    @(negedge clk); region_mask = 20'hFFFFF;
    rd(20'h00000, 16'h5A5A, q); chk("R12 chip region", q, stat(0, m6, m2)); m6 = ~m6; m2 = ~m2;
    rd(20'hFFFFF, 16'h5A5A, q); chk("R12 chip region", q, stat(0, m6, m2)); m6 = ~m6; m2 = ~m2;
    @(negedge clk); op_busy = 0; op_erase = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_program();
    t_complete();
    t_erase();
    t_suspend();
    t_resume();
    t_chip();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule